// File: doc/BRIEF.md
# Bus Hold Arbitration Handshake

This block is the processor-side half of a bus hand-over protocol. Another bus master raises a hold request. The block first stops the internal bus engine from starting new work. It then waits until the bus reaches a safe point: no single cycle in flight, no burst partly transferred, and no locked sequence open. In the clock in which it gives the bus away, it drops the output enable for the address, data and control pins and raises hold acknowledge. The bus stays released for as long as the request stays high. Once the request is seen low, the block takes the bus back and drops acknowledge in the same clock.

The request input has no internal pull-down. It is sampled on the rising clock edge by a register chain whose length is a parameter, and the default is one register. The state machine has three states:
- `ST_RUN`: the processor owns the bus.
- `ST_DRAIN`: a hold is pending and the current activity is finishing.
- `ST_HELD`: the bus is released.

The machine has five named transitions:
- RUN→HELD (grant_now): the sampled request is high and the bus is already at a safe point.
- RUN→DRAIN (defer): the sampled request is high and the bus is busy.
- DRAIN→HELD (grant_late): the bus reaches a safe point.
- DRAIN→RUN (withdraw): the sampled request drops before the grant.
- HELD→RUN (reclaim): the sampled request drops.

In three-state test mode, both the acknowledge driver and the bus pin drivers are switched off.

Top module: `bus_hold_arbiter`

## Requirements
- R1: A safe point in a clock means `lock_active` is 0 and either `cyc_active` is 0 or `burst_last` is 1. Acknowledge rises only on the edge after a clock in which the sampled request is 1 and a safe point holds. With the default single sampling stage, a request raised while idle gives `hold_ack`=1 two rising edges later.
- R2: Outside test mode, `bus_oe` is always the inverse of `hold_ack`, so the float and the acknowledge change in the same clock.
- R3: While the sampled request stays 1, `hold_ack` stays 1 once granted.
- R4: On the edge after the sampled request is seen 0 in `ST_HELD`, `hold_ack` goes to 0 and `bus_oe` goes to 1 together.
- R5: If the request drops during `ST_DRAIN`, the block returns to `ST_RUN` without ever asserting `hold_ack`.
- R6: `hold_ack_oe` is 1 except when `test_tristate` is 1. In test mode, both `hold_ack_oe` and `bus_oe` are 0.
- R7: `engine_stall` is 1 whenever the sampled request is 1 or the state is not `ST_RUN`.
- R8: After reset, the state is `ST_RUN`, `hold_ack`=0, `bus_oe`=1 and `engine_stall`=0.
- R9: A burst (`cyc_active`=1 with `burst_last`=0) defers the grant until the clock of its last transfer. `lock_active`=1 defers it even while no cycle is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_req | input | 1 | Bus hold request from another master |
| cyc_active | input | 1 | A bus cycle is in progress this clock |
| burst_last | input | 1 | The current transfer is the last of its cycle or burst |
| lock_active | input | 1 | A locked cycle sequence is open |
| test_tristate | input | 1 | Three-state test mode |
| hold_ack | output | 1 | Hold acknowledge level |
| hold_ack_oe | output | 1 | Driver enable for the acknowledge pin |
| bus_oe | output | 1 | Output enable for address, data and control pins |
| engine_stall | output | 1 | Stops the internal bus engine from starting a cycle |

## Verification
With one sampling stage, a request change reaches the sampled flag on the first rising edge. The state then moves on the second edge, provided a safe point holds in the clock before that edge. So acknowledge rises two edges after an idle request and falls two edges after the request drops. `engine_stall` follows one edge after the request. The drivers respond to `test_tristate` within the same clock.

The bench drives inputs 2 ns after a rising edge and checks at that same point. It counts whole edges between each stimulus and the check that depends on it. A behavioural model tracks the sampled request and the state, and is compared with the outputs at every falling edge.

// File: rtl/bha_pkg.sv
package bha_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_HELD  = 2'd2
    } bha_state_t;
endpackage

// File: rtl/bha_hold_sampler.sv
module bha_hold_sampler #(
    parameter int SYNC_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    output logic req_q
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] pipe;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= 1'b0;
                    else        pipe[g] <= req_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= 1'b0;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign req_q = pipe[LAST];
endmodule

// File: rtl/bha_idle_detect.sv
module bha_idle_detect (
    input  logic cyc_active,
    input  logic burst_last,
    input  logic lock_active,
    output logic safe_point
);
    logic cycle_open;

    always_comb begin
        // A cycle still owns the bus unless this is its final transfer.
        cycle_open = cyc_active && !burst_last;
        safe_point = !lock_active && !cycle_open;
    end
endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
    import bha_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_q,
    input  logic safe_point,
    input  logic test_tristate,
    output logic hold_ack,
    output logic hold_ack_oe,
    output logic bus_oe,
    output logic engine_stall
);
    bha_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (hold_q) state_nx = safe_point ? ST_HELD : ST_DRAIN; // grant_now / defer
            end
            ST_DRAIN: begin
                if (!hold_q)        state_nx = ST_RUN;  // withdraw
                else if (safe_point) state_nx = ST_HELD; // grant_late
            end
            ST_HELD: begin
                if (!hold_q) state_nx = ST_RUN;          // reclaim
            end
            default: state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        hold_ack     = (state == ST_HELD);
        hold_ack_oe  = !test_tristate;
        bus_oe       = !test_tristate && (state != ST_HELD);
        engine_stall = hold_q || (state != ST_RUN);
    end

    assert_held_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && hold_q) |=> (state == ST_HELD));

    assert_reclaim_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && !hold_q) |=> (state == ST_RUN));

    assert_withdraw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !hold_q) |=> (state == ST_RUN));

    assert_stall_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> engine_stall);
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
    parameter int SYNC_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic cyc_active,
    input  logic burst_last,
    input  logic lock_active,
    input  logic test_tristate,
    output logic hold_ack,
    output logic hold_ack_oe,
    output logic bus_oe,
    output logic engine_stall
);
    logic hold_q;
    logic safe_point;

    bha_hold_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (hold_req),
        .req_q  (hold_q)
    );

    bha_idle_detect u_idle (
        .cyc_active  (cyc_active),
        .burst_last  (burst_last),
        .lock_active (lock_active),
        .safe_point  (safe_point)
    );

    bha_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hold_q        (hold_q),
        .safe_point    (safe_point),
        .test_tristate (test_tristate),
        .hold_ack      (hold_ack),
        .hold_ack_oe   (hold_ack_oe),
        .bus_oe        (bus_oe),
        .engine_stall  (engine_stall)
    );

    assert_grant_at_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(!lock_active && (!cyc_active || burst_last)));

    assert_float_with_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !test_tristate |-> (hold_ack != bus_oe));

    assert_test_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        test_tristate |-> (!hold_ack_oe && !bus_oe));
endmodule

// File: tb/bus_hold_arbiter_bench.sv
module bus_hold_arbiter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req = 1'b0, cyc_active = 1'b0, burst_last = 1'b0;
    logic lock_active = 1'b0, test_tristate = 1'b0;
    logic hold_ack, hold_ack_oe, bus_oe, engine_stall;

    int checks = 0;
    int errors = 0;

    // model: 0 run, 1 drain, 2 held
    int m_st = 0;
    bit m_hq = 1'b0;

    always #5 clk = ~clk;

    bus_hold_arbiter u_bus_hold_arbiter (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .cyc_active(cyc_active),
        .burst_last(burst_last), .lock_active(lock_active), .test_tristate(test_tristate),
        .hold_ack(hold_ack), .hold_ack_oe(hold_ack_oe), .bus_oe(bus_oe),
        .engine_stall(engine_stall)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0;
            m_hq = 1'b0;
        end else begin
            bit safe;
            int nx;
            safe = !lock_active && (!cyc_active || burst_last);
            nx = m_st;
            if (m_st == 0 && m_hq) nx = safe ? 2 : 1;
            else if (m_st == 1) nx = !m_hq ? 0 : (safe ? 2 : 1);
            else if (m_st == 2 && !m_hq) nx = 0;
            m_st = nx;
            m_hq = hold_req;
        end
    end

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check("R1 model hold_ack", hold_ack, m_st == 2);
            check("R2 model bus_oe", bus_oe, !test_tristate && m_st != 2);
            check("R6 model hold_ack_oe", hold_ack_oe, !test_tristate);
            check("R7 model engine_stall", engine_stall, m_hq || m_st != 0);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(2);
        check("R8 reset hold_ack", hold_ack, 1'b0);
        check("R8 reset bus_oe", bus_oe, 1'b1);
        check("R8 reset engine_stall", engine_stall, 1'b0);
        rst_n = 1'b1;
        tick(2);

        // idle grant
        hold_req = 1'b1;
        tick(1);
        check("R1 not yet granted", hold_ack, 1'b0);
        check("R7 stall on sampled request", engine_stall, 1'b1);
        tick(1);
        check("R1 granted after two edges", hold_ack, 1'b1);
        check("R2 bus floated with ack", bus_oe, 1'b0);
        tick(10);
        check("R3 held while requested", hold_ack, 1'b1);
        hold_req = 1'b0;
        tick(1);
        check("R3 still held one edge after drop", hold_ack, 1'b1);
        tick(1);
        check("R4 ack dropped", hold_ack, 1'b0);
        check("R4 bus reclaimed", bus_oe, 1'b1);
        tick(2);

        // burst defers grant
        cyc_active = 1'b1; burst_last = 1'b0; hold_req = 1'b1;
        tick(4);
        check("R9 burst defers grant", hold_ack, 1'b0);
        burst_last = 1'b1;
        tick(1);
        check("R9 grant at last transfer", hold_ack, 1'b1);
        cyc_active = 1'b0; burst_last = 1'b0; hold_req = 1'b0;
        tick(2);
        check("R4 reclaim after burst grant", bus_oe, 1'b1);

        // locked sequence defers grant
        lock_active = 1'b1; hold_req = 1'b1;
        tick(5);
        check("R9 lock defers grant", hold_ack, 1'b0);
        lock_active = 1'b0;
        tick(1);
        check("R9 grant after lock ends", hold_ack, 1'b1);
        hold_req = 1'b0;
        tick(2);

        // withdrawal while draining
        cyc_active = 1'b1; hold_req = 1'b1;
        tick(3);
        check("R5 draining no ack", hold_ack, 1'b0);
        hold_req = 1'b0;
        tick(1);
        check("R5 still stalled in drain", engine_stall, 1'b1);
        tick(1);
        check("R5 back to run no stall", engine_stall, 1'b0);
        check("R5 back to run no ack", hold_ack, 1'b0);
        cyc_active = 1'b0;
        tick(2);

        // test mode
        test_tristate = 1'b1;
        tick(1);
        check("R6 ack driver off in test", hold_ack_oe, 1'b0);
        check("R6 bus driver off in test", bus_oe, 1'b0);
        test_tristate = 1'b0;
        tick(1);
        check("R6 ack driver on", hold_ack_oe, 1'b1);

        // random traffic compared against the model every clock
        for (int i = 0; i < 400; i++) begin
            hold_req    = ($urandom % 4) != 0 ? hold_req : ~hold_req;
            cyc_active  = $urandom % 2;
            burst_last  = ($urandom % 3) == 0;
            lock_active = ($urandom % 5) == 0;
            test_tristate = ($urandom % 16) == 0;
            tick(1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule